// File: doc/BRIEF.md
# Link Power and Speed State Controller

This controller sits on the link-layer side of a USB 2.0 transceiver. It reads the two-bit line state and drives the transceiver's control outputs: the speed select, the termination select, the active-low suspend control, the operating mode, and a transmit-valid strobe. The transmit-valid strobe is used only while the controller itself signals on the bus (device chirp, remote wake). When this controller owns the transmit path, the data byte presented to the transceiver must be all zeros, which makes the line go to K.

The controller times bus inactivity in millisecond ticks. In high-speed operation the idle state is SE0. A long idle period therefore cannot be classed as suspend or bus reset until the controller has dropped back to full-speed select and terminations and sampled the line again. A J on the line then means suspend, and an SE0 means reset. A reset starts the high-speed detection handshake: the device sends a chirp K, then listens for alternating K/J chirps from the hub. The controller also handles host-driven resume, and it can start remote wake signalling itself. It remembers the speed it last negotiated and returns to that speed after a resume.

Time is counted in pulses of a `ms_tick` input, and every duration is a parameter, so simulation can run on a short time base.

Top module: `link_state_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, the outputs are full-speed idle: `xcvr_hs`=0, `term_hs`=0, `susp_n`=1, `op_mode`=00, `tx_valid`=0.
- R2: Line codes are 00 = SE0, 01 = J, 10 = K and 11 = invalid. In high-speed operation, SE0 held continuously for IDLE_MS ticks drops `xcvr_hs` and `term_hs` to 0 while `susp_n` stays 1. A J, K or 11 sample restarts this count.
- R3: After the drop to full speed, the line is sampled once SETTLE_CYC cycles have passed. If it shows J, `susp_n` goes to 0 and `term_hs` stays 0.
- R4: If that sample shows SE0, or a full-speed reset is detected (see R9), the device chirp runs: `xcvr_hs`=1, `term_hs`=0, `op_mode`=10, `tx_valid`=1 for CHIRP_TX_MS ticks. Then listening begins with `xcvr_hs`=1, `term_hs`=0, `op_mode`=00, `tx_valid`=0.
- R5: While listening, HUB_PAIRS K-then-J pairs, each state held for at least CHIRP_MIN_CYC samples, switch the controller to high speed (`xcvr_hs`=1, `term_hs`=1).
- R6: K or J states held for fewer than CHIRP_MIN_CYC samples do not count toward R5. If no valid sequence arrives within HUB_WAIT_MS ticks, the controller returns to full speed (`xcvr_hs`=0, `term_hs`=0) and records full speed as the negotiated speed.
- R7: While suspended, a J-to-K change on the line raises `susp_n` with both selects still 0. A later K-to-SE0 change restores the recorded speed.
- R8: While suspended, `wake_req` raises `susp_n` and drives `op_mode`=10 with `tx_valid`=1 for RESUME_MS ticks. After that, `op_mode` returns to 00 and `tx_valid` to 0, and the first SE0 restores the recorded speed. `wake_req` has no effect outside suspend.
- R9: In full-speed operation, a J or an SE0 held unchanged for IDLE_MS ticks enters suspend or starts the device chirp, respectively. A K, an 11, or any change of the line restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| line_st | input | 2 | Line state from the transceiver (00 SE0, 01 J, 10 K, 11 invalid) |
| wake_req | input | 1 | Request to signal remote wake while suspended |
| xcvr_hs | output | 1 | 1 selects the high-speed transceiver |
| term_hs | output | 1 | 1 selects high-speed terminations |
| susp_n | output | 1 | 0 puts the transceiver in suspend |
| op_mode | output | 2 | 00 normal, 10 stuffing and NRZI disabled |
| tx_valid | output | 1 | Transmit strobe for chirp K and remote wake K |

## Verification
The hardest situation to reach from the ports is a suspend entered from high speed followed by a resume back to high speed. Reaching it needs a full chain: an idle timeout, the settle sample, a device chirp, a qualified hub sequence, a second idle timeout, and then a J-to-K-to-SE0 or wake sequence. The stimulus table walks that chain one line state and one tick burst at a time. Because the recorded speed is only visible after a resume, the table runs one suspend-and-resume cycle after a successful handshake and another after a handshake that timed out on short chirps. In the second case, a final idle SE0 proves that full speed was remembered.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;

  typedef enum logic [3:0] {
    ST_FS,
    ST_HS,
    ST_CHECK,
    ST_SUSP,
    ST_WAKE,
    ST_CHIRP_TX,
    ST_CHIRP_RX,
    ST_RES_TX,
    ST_RES_WAIT
  } lps_state_e;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  localparam logic [1:0] OPM_NORM = 2'b00;
  localparam logic [1:0] OPM_RAW  = 2'b10;

endpackage

// File: rtl/ms_counter.sv
module ms_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_nx;

  // saturating count of millisecond ticks since the last clear
  always_comb begin
    if (clr)
      cnt_nx = '0;
    else if (tick && (cnt != {W{1'b1}}))
      cnt_nx = cnt + W'(1);
    else
      cnt_nx = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else
      cnt <= cnt_nx;
  end

endmodule

// File: rtl/hub_chirp_det.sv
module hub_chirp_det
  import link_pwr_pkg::*;
#(
  parameter int MIN_HOLD = 8,
  parameter int PAIRS    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] line,
  output logic [1:0] line_prev,
  output logic       hub_ok
);

  localparam int HW = $clog2(MIN_HOLD + 2);
  localparam int PW = $clog2(PAIRS + 1);

  logic [HW-1:0] hold_q, hold_nx;
  logic [PW-1:0] pairs_q, pairs_nx;
  logic          want_k_q, want_k_nx;
  logic          qual;

  // hold_nx = number of consecutive samples equal to the current line
  always_comb begin
    if (line != line_prev)
      hold_nx = HW'(1);
    else if (hold_q == HW'(MIN_HOLD + 1))
      hold_nx = hold_q;
    else
      hold_nx = hold_q + HW'(1);
    qual = (hold_nx == HW'(MIN_HOLD));
  end

  always_comb begin
    pairs_nx  = pairs_q;
    want_k_nx = want_k_q;
    hub_ok    = 1'b0;
    if (!en) begin
      pairs_nx  = '0;
      want_k_nx = 1'b1;
    end else if (qual) begin
      case (line)
        LS_K: begin
          if (!want_k_q) pairs_nx = '0;
          want_k_nx = 1'b0;
        end
        LS_J: begin
          if (!want_k_q) begin
            pairs_nx = pairs_q + PW'(1);
            hub_ok   = (pairs_q + PW'(1)) == PW'(PAIRS);
          end else begin
            pairs_nx = '0;
          end
          want_k_nx = 1'b1;
        end
        default: begin
          pairs_nx  = '0;
          want_k_nx = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev <= LS_J;
      hold_q    <= HW'(MIN_HOLD + 1);
      pairs_q   <= '0;
      want_k_q  <= 1'b1;
    end else begin
      line_prev <= line;
      hold_q    <= hold_nx;
      pairs_q   <= pairs_nx;
      want_k_q  <= want_k_nx;
    end
  end

endmodule

// File: rtl/link_state_ctrl.sv
module link_state_ctrl
  import link_pwr_pkg::*;
#(
  parameter int IDLE_MS       = 3,
  parameter int CHIRP_TX_MS   = 1,
  parameter int HUB_WAIT_MS   = 3,
  parameter int RESUME_MS     = 2,
  parameter int CHIRP_MIN_CYC = 8,
  parameter int HUB_PAIRS     = 3,
  parameter int SETTLE_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [1:0] line_st,
  input  logic       wake_req,
  output logic       xcvr_hs,
  output logic       term_hs,
  output logic       susp_n,
  output logic [1:0] op_mode,
  output logic       tx_valid
);

  localparam int TW = $clog2(IDLE_MS + CHIRP_TX_MS + HUB_WAIT_MS + RESUME_MS + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  lps_state_e    state_q, state_nx;
  logic          was_hs_q, was_hs_nx;
  logic [SW-1:0] settle_q, settle_nx;
  logic [TW-1:0] idle_cnt, st_cnt;
  logic [1:0]    line_prev;
  logic          hub_ok, idle_run, idle_clr, st_clr, idle_done, settled;

  hub_chirp_det #(
    .MIN_HOLD (CHIRP_MIN_CYC),
    .PAIRS    (HUB_PAIRS)
  ) u_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (state_q == ST_CHIRP_RX),
    .line      (line_st),
    .line_prev (line_prev),
    .hub_ok    (hub_ok)
  );

  ms_counter #(.W(TW)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idle_clr),
    .tick  (ms_tick),
    .cnt   (idle_cnt)
  );

  ms_counter #(.W(TW)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_clr),
    .tick  (ms_tick),
    .cnt   (st_cnt)
  );

  // inactivity qualifier: line unchanged and at the idle value of the mode
  always_comb begin
    case (state_q)
      ST_HS:   idle_run = (line_st == LS_SE0) && (line_st == line_prev);
      ST_FS:   idle_run = ((line_st == LS_J) || (line_st == LS_SE0)) &&
                          (line_st == line_prev);
      default: idle_run = 1'b0;
    endcase
    idle_done = idle_cnt >= TW'(IDLE_MS);
    settled   = settle_q == SW'(SETTLE_CYC);
    st_clr    = state_nx != state_q;
    idle_clr  = !idle_run || st_clr;
    settle_nx = ((state_q == ST_CHECK) && !settled) ? settle_q + SW'(1) : '0;
  end

  always_comb begin
    state_nx  = state_q;
    was_hs_nx = was_hs_q;
    case (state_q)
      ST_FS:
        if (idle_run && idle_done)
          state_nx = (line_st == LS_J) ? ST_SUSP : ST_CHIRP_TX;
      ST_HS:
        if (idle_run && idle_done) state_nx = ST_CHECK;
      ST_CHECK:
        if (settled) begin
          if (line_st == LS_J)        state_nx = ST_SUSP;
          else if (line_st == LS_SE0) state_nx = ST_CHIRP_TX;
          else                        state_nx = ST_FS;
        end
      ST_SUSP:
        if ((line_prev == LS_J) && (line_st == LS_K)) state_nx = ST_WAKE;
        else if (wake_req)                            state_nx = ST_RES_TX;
      ST_WAKE:
        if ((line_prev == LS_K) && (line_st == LS_SE0))
          state_nx = was_hs_q ? ST_HS : ST_FS;
      ST_CHIRP_TX:
        if (st_cnt >= TW'(CHIRP_TX_MS)) state_nx = ST_CHIRP_RX;
      ST_CHIRP_RX:
        if (hub_ok) begin
          state_nx  = ST_HS;
          was_hs_nx = 1'b1;
        end else if (st_cnt >= TW'(HUB_WAIT_MS)) begin
          state_nx  = ST_FS;
          was_hs_nx = 1'b0;
        end
      ST_RES_TX:
        if (st_cnt >= TW'(RESUME_MS)) state_nx = ST_RES_WAIT;
      ST_RES_WAIT:
        if (line_st == LS_SE0) state_nx = was_hs_q ? ST_HS : ST_FS;
      default: state_nx = ST_FS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_FS;
      was_hs_q <= 1'b0;
      settle_q <= '0;
    end else begin
      state_q  <= state_nx;
      was_hs_q <= was_hs_nx;
      settle_q <= settle_nx;
    end
  end

  // output decode
  always_comb begin
    xcvr_hs  = 1'b0;
    term_hs  = 1'b0;
    susp_n   = 1'b1;
    op_mode  = OPM_NORM;
    tx_valid = 1'b0;
    case (state_q)
      ST_HS: begin
        xcvr_hs = 1'b1;
        term_hs = 1'b1;
      end
      ST_SUSP: susp_n = 1'b0;
      ST_CHIRP_TX: begin
        xcvr_hs  = 1'b1;
        op_mode  = OPM_RAW;
        tx_valid = 1'b1;
      end
      ST_CHIRP_RX: xcvr_hs = 1'b1;
      ST_RES_TX: begin
        op_mode  = OPM_RAW;
        tx_valid = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/link_state_ctrl_chk.sv
module link_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xcvr_hs,
  input logic       term_hs,
  input logic       susp_n,
  input logic [1:0] op_mode,
  input logic       tx_valid
);

  // R3
  susp_fs_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !susp_n |-> (!term_hs && !xcvr_hs && !tx_valid));

  // R4
  raw_mode_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (op_mode == 2'b10));

  // R5
  hs_term_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_hs |-> (xcvr_hs && susp_n && !tx_valid));

  // R2
  hs_leave_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(term_hs) |-> (susp_n && !xcvr_hs && !tx_valid));

  // R7
  wake_keep_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_n) |-> !term_hs);

  // R8
  wake_tx_from_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_valid) && !xcvr_hs) |-> $past(!susp_n));

endmodule

bind link_state_ctrl link_state_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .xcvr_hs  (xcvr_hs),
  .term_hs  (term_hs),
  .susp_n   (susp_n),
  .op_mode  (op_mode),
  .tx_valid (tx_valid)
);

// File: tb/sim_link_state_ctrl.sv
module sim_link_state_ctrl;

  logic       clk;
  logic       rst_n;
  logic       ms_tick;
  logic [1:0] line_st;
  logic       wake_req;
  logic       xcvr_hs, term_hs, susp_n, tx_valid;
  logic [1:0] op_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  link_state_ctrl #(
    .IDLE_MS       (3),
    .CHIRP_TX_MS   (1),
    .HUB_WAIT_MS   (2),
    .RESUME_MS     (1),
    .CHIRP_MIN_CYC (4),
    .HUB_PAIRS     (3),
    .SETTLE_CYC    (3)
  ) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_tick  (ms_tick),
    .line_st  (line_st),
    .wake_req (wake_req),
    .xcvr_hs  (xcvr_hs),
    .term_hs  (term_hs),
    .susp_n   (susp_n),
    .op_mode  (op_mode),
    .tx_valid (tx_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam logic [1:0] S = 2'b00, J = 2'b01, K = 2'b10, X = 2'b11;
  // expected {xcvr_hs, term_hs, susp_n, op_mode, tx_valid}
  localparam logic [5:0] O_FS  = 6'b001000;
  localparam logic [5:0] O_HS  = 6'b111000;
  localparam logic [5:0] O_SUS = 6'b000000;
  localparam logic [5:0] O_CTX = 6'b101101;
  localparam logic [5:0] O_CRX = 6'b101000;
  localparam logic [5:0] O_RTX = 6'b001101;

  // {wake_req, line, ticks, extra cycles, expected, requirement}
  localparam int NV = 42;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, J, 4'd2, 4'd1, O_FS,  4'd9},  // R9 below limit
    {1'b0, K, 4'd0, 4'd2, O_FS,  4'd9},  // R9 K restarts
    {1'b0, J, 4'd2, 4'd1, O_FS,  4'd9},  // R9
    {1'b0, J, 4'd1, 4'd2, O_SUS, 4'd9},  // R9 J idle -> suspend
    {1'b0, K, 4'd0, 4'd2, O_FS,  4'd7},  // R7 J->K wakes
    {1'b0, S, 4'd0, 4'd2, O_FS,  4'd7},  // R7 back to full speed
    {1'b0, S, 4'd3, 4'd2, O_CTX, 4'd9},  // R9 SE0 idle -> chirp
    {1'b0, S, 4'd1, 4'd2, O_CRX, 4'd4},  // R4 chirp ends
    {1'b0, K, 4'd0, 4'd5, O_CRX, 4'd5},  // R5
    {1'b0, J, 4'd0, 4'd5, O_CRX, 4'd5},
    {1'b0, K, 4'd0, 4'd5, O_CRX, 4'd5},
    {1'b0, J, 4'd0, 4'd5, O_CRX, 4'd5},
    {1'b0, K, 4'd0, 4'd5, O_CRX, 4'd5},
    {1'b0, J, 4'd0, 4'd5, O_HS,  4'd5},  // R5 third pair
    {1'b0, S, 4'd3, 4'd1, O_FS,  4'd2},  // R2 fallback
    {1'b0, J, 4'd0, 4'd4, O_SUS, 4'd3},  // R3 suspend
    {1'b0, K, 4'd0, 4'd2, O_FS,  4'd7},  // R7
    {1'b0, S, 4'd0, 4'd2, O_HS,  4'd7},  // R7 back to high speed
    {1'b0, S, 4'd3, 4'd1, O_FS,  4'd2},  // R2
    {1'b0, J, 4'd0, 4'd4, O_SUS, 4'd3},  // R3
    {1'b1, J, 4'd0, 4'd2, O_RTX, 4'd8},  // R8 remote wake drive
    {1'b0, K, 4'd1, 4'd2, O_FS,  4'd8},  // R8 drive ends
    {1'b0, K, 4'd0, 4'd2, O_FS,  4'd8},  // R8 waits for SE0
    {1'b0, S, 4'd0, 4'd2, O_HS,  4'd8},  // R8 high speed restored
    {1'b0, S, 4'd2, 4'd1, O_HS,  4'd2},  // R2
    {1'b0, X, 4'd0, 4'd1, O_HS,  4'd2},  // R2 invalid restarts
    {1'b0, S, 4'd2, 4'd1, O_HS,  4'd2},  // R2
    {1'b0, S, 4'd1, 4'd1, O_FS,  4'd2},  // R2
    {1'b0, S, 4'd0, 4'd6, O_CTX, 4'd4},  // R4 reset path
    {1'b0, S, 4'd1, 4'd2, O_CRX, 4'd4},  // R4
    {1'b0, K, 4'd0, 4'd2, O_CRX, 4'd6},  // R6 short chirps
    {1'b0, J, 4'd0, 4'd2, O_CRX, 4'd6},
    {1'b0, K, 4'd0, 4'd2, O_CRX, 4'd6},
    {1'b0, J, 4'd0, 4'd2, O_CRX, 4'd6},
    {1'b0, K, 4'd0, 4'd2, O_CRX, 4'd6},
    {1'b0, J, 4'd0, 4'd2, O_CRX, 4'd6},
    {1'b0, S, 4'd2, 4'd2, O_FS,  4'd6},  // R6 timeout
    {1'b0, J, 4'd3, 4'd2, O_SUS, 4'd9},  // R9
    {1'b1, J, 4'd0, 4'd2, O_RTX, 4'd8},  // R8
    {1'b0, K, 4'd1, 4'd2, O_FS,  4'd8},  // R8
    {1'b0, S, 4'd0, 4'd2, O_FS,  4'd8},  // R8 full speed restored
    {1'b0, S, 4'd3, 4'd2, O_CTX, 4'd6}   // R6 full speed was recorded
  };

  task automatic check(input logic [5:0] exp, input int rq, input int idx);
    logic [5:0] got;
    got = {xcvr_hs, term_hs, susp_n, op_mode, tx_valid};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d step %0d: got %b expected %b", rq, idx, got, exp);
    end
  endtask

  task automatic run_vec(input logic [20:0] v, input int idx);
    wake_req = v[20];
    line_st  = v[19:18];
    for (int t = 0; t < int'(v[17:14]); t++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
    for (int c = 0; c < int'(v[13:10]); c++) @(negedge clk);
    check(v[9:4], int'(v[3:0]), idx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    ms_tick  = 1'b0;
    line_st  = J;
    wake_req = 1'b0;
    repeat (3) @(negedge clk);
    check(O_FS, 1, -1);               // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(O_FS, 1, -2);               // R1 after release

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R1: asynchronous reset in the middle of a device chirp
    rst_n = 1'b0;
    @(negedge clk);
    check(O_FS, 1, 100);
    line_st = J;
    rst_n   = 1'b1;
    // R8: wake request outside suspend has no effect
    wake_req = 1'b1;
    repeat (4) @(negedge clk);
    check(O_FS, 8, 101);
    wake_req = 1'b0;
    // R9: a change from J to SE0 restarts the idle count
    run_vec({1'b0, J, 4'd2, 4'd1, O_FS, 4'd9}, 102);
    run_vec({1'b0, S, 4'd2, 4'd1, O_FS, 4'd9}, 103);
    run_vec({1'b0, S, 4'd1, 4'd2, O_CTX, 4'd9}, 104);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule